// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block moves data from memory to memory on behalf of a set of DMA channels. A descriptor loader writes each channel's source address, destination address, control word and configuration word through a load port. A request pulse then starts the engine. The engine scans the channels in ascending order. Each enabled, non-halted channel gets one transfer unit per visit, so several active channels interleave one unit at a time.

A transfer unit has two steps. The engine first reads one source-width item. It then writes that item out as one or more destination-width pieces at consecutive byte offsets. After each unit, the engine updates the channel's addresses and merges the decremented count back into the control word. It reports the new state on a write-back strobe. When the count reaches zero, it pulses completion to the loader and clears the channel's enable.

Only the memory-to-memory flow type is served. Any other flow type, or a width code the data bus cannot carry, raises an error pulse for that channel and disables it. The memory side uses a single valid/ready handshake with one access in flight.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `wb_valid`, `done_valid` and `err_valid` are all low.
- R2: A channel is serviced only when configuration bit 0 (enable) is 1 and bit 18 (halt) is 0. While `glob_en` is low, a request is ignored and the engine stays idle.
- R3: Each unit starts with one read at the channel's source address with `mem_size` = control bits [20:18] (bytes = 1 << code). When control bit 26 is set, the source address then advances by the source width.
- R4: After the read, the engine writes max(1, S/D) pieces with `mem_size` = control bits [23:21], where S and D are the source and destination widths in bytes. Piece k goes to destination + k*D and carries the read data shifted right by 8*k*D bits.
- R5: When control bit 27 is set, the destination address advances by the source width (not the destination width) after each unit.
- R6: After the last write of a unit, `wb_valid` pulses for one cycle with the channel, the new addresses and the control word. That control word keeps bits [31:12] and holds count (bits [11:0]) minus one.
- R7: When the count reaches zero, `done_valid` pulses with the channel and its enable is cleared. An enabled channel loaded with count zero completes at once with no memory access.
- R8: A serviced channel whose flow type (configuration bits [13:11]) is not 0, or whose width code exceeds log2 of the bus bytes, makes `err_valid` pulse with the channel. That channel's enable is cleared and no memory access is made for it.
- R9: Within a pass, channels are visited in ascending order and each eligible channel performs at most one unit per visit.
- R10: A pass takes at least one cycle per channel. A new pass follows if any channel was serviced or a request arrived during the pass. Otherwise `busy` falls.
- R11: While `mem_valid` is high and `mem_ready` low, `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` hold. `mem_valid` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Controller-wide enable |
| req_i | input | 1 | Request pulse that starts or extends scanning |
| ld_valid | input | 1 | Channel load strobe |
| ld_ch | input | CHW | Channel being loaded |
| ld_src | input | AW | Source address |
| ld_dst | input | AW | Destination address |
| ld_ctrl | input | 32 | Control word |
| ld_conf | input | 32 | Configuration word |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 3 | log2 of access bytes |
| mem_wdata | output | DW | Write data, low-aligned |
| mem_rdata | input | DW | Read data, low-aligned |
| mem_ready | input | 1 | Access accepted / data valid |
| busy | output | 1 | Engine scanning |
| wb_valid | output | 1 | Unit finished strobe |
| wb_ch | output | CHW | Channel of the write-back |
| wb_src | output | AW | Updated source address |
| wb_dst | output | AW | Updated destination address |
| wb_ctrl | output | 32 | Updated control word |
| done_valid | output | 1 | Channel count exhausted |
| done_ch | output | CHW | Completed channel |
| err_valid | output | 1 | Unsupported configuration |
| err_ch | output | CHW | Faulting channel |

## Verification
The main sweep covers every legal pairing of source and destination width, all four increment combinations and counts of one to three units. A byte-level model of memory predicts the destination contents, the number of writes and the final addresses. Narrow-to-wide pairings show whether bytes above the source width are zero-filled. Wide-to-narrow pairings show the per-piece offset and shift. Runs with increments off show whether an address that should stay fixed moves. A run with two active channels separates per-unit interleaving from draining one channel at a time. Runs with no active channel, where a second request arrives mid-pass, show whether a pending request buys exactly one extra pass.

// File: rtl/dma_xe_pkg.sv
`timescale 1ns/1ps
package dma_xe_pkg;
  localparam int CTRL_W       = 32;
  localparam int CNT_W        = 12;
  localparam int SWC_LSB      = 18;
  localparam int DWC_LSB      = 21;
  localparam int SINC_BIT     = 26;
  localparam int DINC_BIT     = 27;
  localparam int CF_EN_BIT    = 0;
  localparam int CF_HALT_BIT  = 18;
  localparam int CF_FLOW_LSB  = 11;
  localparam logic [2:0] FLOW_MEM2MEM = 3'd0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } xe_state_e;

  typedef struct packed {
    logic             elig;
    logic             fault;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       swc;
    logic [2:0]       dwc;
    logic             sinc;
    logic             dinc;
  } xe_dec_t;
endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_xe_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [CHW-1:0]    ld_ch,
  input  logic [AW-1:0]     ld_src,
  input  logic [AW-1:0]     ld_dst,
  input  logic [CTRL_W-1:0] ld_ctrl,
  input  logic              ld_en,
  input  logic              ld_halt,
  input  logic [2:0]        ld_flow,
  input  logic              upd_valid,
  input  logic [CHW-1:0]    upd_ch,
  input  logic [AW-1:0]     upd_src,
  input  logic [AW-1:0]     upd_dst,
  input  logic [CTRL_W-1:0] upd_ctrl,
  input  logic              clr_valid,
  output logic [AW-1:0]     src_q  [NCH],
  output logic [AW-1:0]     dst_q  [NCH],
  output logic [CTRL_W-1:0] ctrl_q [NCH],
  output logic [NCH-1:0]    en_q,
  output logic [NCH-1:0]    halt_q,
  output logic [2:0]        flow_q [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit_ld, hit_up, hit_clr;
    logic              ce_addr, ce_cfg;
    logic [AW-1:0]     s_q, s_n, d_q, d_n;
    logic [CTRL_W-1:0] k_q, k_n;
    logic              e_q, e_n, h_q, h_n;
    logic [2:0]        f_q, f_n;

    assign hit_ld  = ld_valid  && (ld_ch  == CHW'(c));
    assign hit_up  = upd_valid && (upd_ch == CHW'(c));
    assign hit_clr = clr_valid && (upd_ch == CHW'(c));
    assign ce_addr = hit_ld || hit_up;
    assign ce_cfg  = hit_ld || hit_clr;

    always_comb begin
      s_n = hit_ld ? ld_src  : upd_src;
      d_n = hit_ld ? ld_dst  : upd_dst;
      k_n = hit_ld ? ld_ctrl : upd_ctrl;
      e_n = hit_ld ? ld_en   : 1'b0;
      h_n = hit_ld ? ld_halt : h_q;
      f_n = hit_ld ? ld_flow : f_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        d_q <= '0;
        k_q <= '0;
      end else if (ce_addr) begin
        s_q <= s_n;
        d_q <= d_n;
        k_q <= k_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= 1'b0;
        h_q <= 1'b0;
        f_q <= '0;
      end else if (ce_cfg) begin
        e_q <= e_n;
        h_q <= h_n;
        f_q <= f_n;
      end
    end

    assign src_q[c]  = s_q;
    assign dst_q[c]  = d_q;
    assign ctrl_q[c] = k_q;
    assign en_q[c]   = e_q;
    assign halt_q[c] = h_q;
    assign flow_q[c] = f_q;
  end
endmodule

// File: rtl/dma_word_decode.sv
`timescale 1ns/1ps
module dma_word_decode
  import dma_xe_pkg::*;
#(
  parameter int DW = 32,
  localparam int WLOG = $clog2(DW/8)
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              en,
  input  logic              halt,
  input  logic [2:0]        flow,
  output xe_dec_t           dec
);
  localparam logic [2:0] MAXC = 3'(WLOG);

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl[CTRL_W-1:DINC_BIT+1], ctrl[DWC_LSB+5:DWC_LSB+3],
                         ctrl[SWC_LSB-1:CNT_W]};

  always_comb begin
    dec.elig  = en && !halt;
    dec.cnt   = ctrl[CNT_W-1:0];
    dec.swc   = ctrl[SWC_LSB +: 3];
    dec.dwc   = ctrl[DWC_LSB +: 3];
    dec.sinc  = ctrl[SINC_BIT];
    dec.dinc  = ctrl[DINC_BIT];
    dec.fault = (flow != FLOW_MEM2MEM) || (dec.swc > MAXC) || (dec.dwc > MAXC);
  end
endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
  import dma_xe_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int CHW  = $clog2(NCH),
  localparam int OFW  = $clog2(DW/8) + 1,
  localparam int HI_W = CTRL_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              req_i,
  input  xe_dec_t           dec,
  input  logic [AW-1:0]     cur_src,
  input  logic [AW-1:0]     cur_dst,
  input  logic [HI_W-1:0]   cur_ctrl_hi,
  output logic [CHW-1:0]    idx,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [2:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ready,
  output logic              upd_valid,
  output logic [AW-1:0]     upd_src,
  output logic [AW-1:0]     upd_dst,
  output logic [CTRL_W-1:0] upd_ctrl,
  output logic              clr_valid,
  output logic              busy,
  output logic              wb_valid,
  output logic              done_valid,
  output logic              err_valid,
  output logic [CHW-1:0]    ev_ch,
  output logic [AW-1:0]     wb_src,
  output logic [AW-1:0]     wb_dst,
  output logic [CTRL_W-1:0] wb_ctrl
);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  xe_state_e        st_q, st_n;
  logic [CHW-1:0]   idx_q, idx_n;
  logic             srv_q, srv_n, pend_q, pend_n;
  logic [DW-1:0]    rbuf_q, rbuf_n;
  logic [OFW-1:0]   off_q, off_n;
  logic             wb_n, done_n, err_n;
  logic             step, step_srv;
  logic             ce_rbuf, ce_ev;
  logic [OFW-1:0]   sbytes, dbytes, off_nx;
  logic [CNT_W-1:0] cnt_dec;

  assign sbytes  = OFW'(1) << dec.swc;
  assign dbytes  = OFW'(1) << dec.dwc;
  assign off_nx  = off_q + dbytes;
  assign cnt_dec = dec.cnt - CNT_W'(1);

  assign upd_src  = dec.sinc ? cur_src + AW'(sbytes) : cur_src;
  assign upd_dst  = dec.dinc ? cur_dst + AW'(sbytes) : cur_dst;
  assign upd_ctrl = {cur_ctrl_hi, cnt_dec};

  always_comb begin
    st_n      = st_q;
    idx_n     = idx_q;
    srv_n     = srv_q;
    pend_n    = pend_q || (req_i && st_q != ST_IDLE);
    rbuf_n    = rbuf_q;
    off_n     = off_q;
    upd_valid = 1'b0;
    clr_valid = 1'b0;
    wb_n      = 1'b0;
    done_n    = 1'b0;
    err_n     = 1'b0;
    step      = 1'b0;
    step_srv  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        pend_n = 1'b0;
        if (req_i && glob_en) begin
          st_n  = ST_SCAN;
          idx_n = '0;
          srv_n = 1'b0;
        end
      end
      ST_SCAN: begin
        if (!glob_en) begin
          st_n   = ST_IDLE;
          pend_n = 1'b0;
        end else if (dec.elig) begin
          if (dec.fault) begin
            err_n     = 1'b1;
            clr_valid = 1'b1;
            step      = 1'b1;
            step_srv  = 1'b1;
          end else if (dec.cnt == '0) begin
            done_n    = 1'b1;
            clr_valid = 1'b1;
            step      = 1'b1;
            step_srv  = 1'b1;
          end else begin
            st_n = ST_READ;
          end
        end else begin
          step = 1'b1;
        end
      end
      ST_READ: begin
        if (mem_ready) begin
          rbuf_n = mem_rdata;
          off_n  = '0;
          st_n   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          if (off_nx >= sbytes) begin
            upd_valid = 1'b1;
            wb_n      = 1'b1;
            if (cnt_dec == '0) begin
              done_n    = 1'b1;
              clr_valid = 1'b1;
            end
            step     = 1'b1;
            step_srv = 1'b1;
          end else begin
            off_n = off_nx;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (step) begin
      if (idx_q == LAST) begin
        if (srv_q || step_srv || pend_n) begin
          st_n   = ST_SCAN;
          idx_n  = '0;
          srv_n  = 1'b0;
          pend_n = 1'b0;
        end else begin
          st_n = ST_IDLE;
        end
      end else begin
        st_n  = ST_SCAN;
        idx_n = idx_q + CHW'(1);
        srv_n = srv_q || step_srv;
      end
    end
  end

  assign ce_rbuf = (st_q == ST_READ) && mem_ready;
  assign ce_ev   = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      srv_q  <= 1'b0;
      pend_q <= 1'b0;
      off_q  <= '0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      srv_q  <= srv_n;
      pend_q <= pend_n;
      off_q  <= off_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbuf_q <= '0;
    else if (ce_rbuf) rbuf_q <= rbuf_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      done_valid <= 1'b0;
      err_valid  <= 1'b0;
    end else begin
      wb_valid   <= wb_n;
      done_valid <= done_n;
      err_valid  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_ch   <= '0;
      wb_src  <= '0;
      wb_dst  <= '0;
      wb_ctrl <= '0;
    end else if (ce_ev) begin
      ev_ch   <= idx_q;
      wb_src  <= upd_src;
      wb_dst  <= upd_dst;
      wb_ctrl <= upd_ctrl;
    end
  end

  assign idx       = idx_q;
  assign busy      = (st_q != ST_IDLE);
  assign mem_valid = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we    = (st_q == ST_WRITE);
  assign mem_addr  = (st_q == ST_WRITE) ? cur_dst + AW'(off_q) : cur_src;
  assign mem_size  = (st_q == ST_WRITE) ? dec.dwc : dec.swc;
  assign mem_wdata = rbuf_q >> {off_q, 3'b000};
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
  import dma_xe_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              req_i,
  input  logic              ld_valid,
  input  logic [CHW-1:0]    ld_ch,
  input  logic [AW-1:0]     ld_src,
  input  logic [AW-1:0]     ld_dst,
  input  logic [31:0]       ld_ctrl,
  input  logic [31:0]       ld_conf,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [2:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              wb_valid,
  output logic [CHW-1:0]    wb_ch,
  output logic [AW-1:0]     wb_src,
  output logic [AW-1:0]     wb_dst,
  output logic [31:0]       wb_ctrl,
  output logic              done_valid,
  output logic [CHW-1:0]    done_ch,
  output logic              err_valid,
  output logic [CHW-1:0]    err_ch
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [AW-1:0]     src_a  [NCH];
  logic [AW-1:0]     dst_a  [NCH];
  logic [CTRL_W-1:0] ctrl_a [NCH];
  logic [2:0]        flow_a [NCH];
  logic [NCH-1:0]    chan_en, chan_halt;
  logic [CHW-1:0]    idx, ev_ch;
  xe_dec_t           dec;
  logic              upd_valid, clr_valid;
  logic [AW-1:0]     upd_src, upd_dst;
  logic [CTRL_W-1:0] upd_ctrl, cur_ctrl;
  logic              unused_conf;

  // Peripheral selects and unused configuration bits carry no meaning here.
  assign unused_conf = ^{ld_conf[31:19], ld_conf[17:14], ld_conf[10:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dma_chan_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ld_valid  (ld_valid),
    .ld_ch     (ld_ch),
    .ld_src    (ld_src),
    .ld_dst    (ld_dst),
    .ld_ctrl   (ld_ctrl),
    .ld_en     (ld_conf[CF_EN_BIT]),
    .ld_halt   (ld_conf[CF_HALT_BIT]),
    .ld_flow   (ld_conf[CF_FLOW_LSB +: 3]),
    .upd_valid (upd_valid),
    .upd_ch    (idx),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_ctrl  (upd_ctrl),
    .clr_valid (clr_valid),
    .src_q     (src_a),
    .dst_q     (dst_a),
    .ctrl_q    (ctrl_a),
    .en_q      (chan_en),
    .halt_q    (chan_halt),
    .flow_q    (flow_a)
  );

  assign cur_ctrl = ctrl_a[idx];

  dma_word_decode #(.DW(DW)) u_dec (
    .ctrl (cur_ctrl),
    .en   (chan_en[idx]),
    .halt (chan_halt[idx]),
    .flow (flow_a[idx]),
    .dec  (dec)
  );

  dma_xfer_seq #(.NCH(NCH), .AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .glob_en     (glob_en),
    .req_i       (req_i),
    .dec         (dec),
    .cur_src     (src_a[idx]),
    .cur_dst     (dst_a[idx]),
    .cur_ctrl_hi (cur_ctrl[CTRL_W-1:CNT_W]),
    .idx         (idx),
    .mem_valid   (mem_valid),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ready   (mem_ready),
    .upd_valid   (upd_valid),
    .upd_src     (upd_src),
    .upd_dst     (upd_dst),
    .upd_ctrl    (upd_ctrl),
    .clr_valid   (clr_valid),
    .busy        (busy),
    .wb_valid    (wb_valid),
    .done_valid  (done_valid),
    .err_valid   (err_valid),
    .ev_ch       (ev_ch),
    .wb_src      (wb_src),
    .wb_dst      (wb_dst),
    .wb_ctrl     (wb_ctrl)
  );

  assign wb_ch   = ev_ch;
  assign done_ch = ev_ch;
  assign err_ch  = ev_ch;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
`timescale 1ns/1ps
module dma_xfer_engine_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           glob_en,
  input logic           busy,
  input logic           ld_valid,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [2:0]     mem_size,
  input logic [DW-1:0]  mem_wdata,
  input logic           wb_valid,
  input logic           done_valid,
  input logic [CHW-1:0] done_ch,
  input logic           err_valid,
  input logic [NCH-1:0] chan_en
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr)
                                && $stable(mem_size) && $stable(mem_wdata)); // R11
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R11
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !glob_en |=> !busy); // R2
  AST_WB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_valid && mem_we && mem_ready)); // R6
  AST_DONE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (!chan_en[done_ch] || $past(ld_valid))); // R7
  AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !$past(mem_valid)); // R8
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glob_en    (glob_en),
  .busy       (busy),
  .ld_valid   (ld_valid),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_size   (mem_size),
  .mem_wdata  (mem_wdata),
  .wb_valid   (wb_valid),
  .done_valid (done_valid),
  .done_ch    (done_ch),
  .err_valid  (err_valid),
  .chan_en    (chan_en)
);

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int CHW = $clog2(NCH);

  logic clk, rst_n, glob_en, req_i, ld_valid;
  logic [CHW-1:0] ld_ch;
  logic [AW-1:0] ld_src, ld_dst;
  logic [31:0] ld_ctrl, ld_conf;
  logic mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [2:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic busy, wb_valid, done_valid, err_valid;
  logic [CHW-1:0] wb_ch, done_ch, err_ch;
  logic [AW-1:0] wb_src, wb_dst;
  logic [31:0] wb_ctrl;

  dma_xfer_engine #(.NCH(NCH), .AW(AW), .DW(DW)) dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int waitc = 0, dly = 0;
  int acc_cnt, wr_cnt, wb_cnt, done_cnt, err_cnt, busy_cyc, hold_bad;
  int last_done_ch, last_err_ch, first_wb_ctrl_lo;
  logic [AW-1:0] last_src, last_dst;
  logic [31:0] last_ctrl;
  int wb_seq [16];
  logic prev_wait;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wdata;
  logic prev_we;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // memory model and event monitor, all at the falling edge
  always @(negedge clk) begin
    if (prev_wait && (!mem_valid || mem_addr != prev_addr || mem_we != prev_we ||
                      mem_wdata != prev_wdata))
      hold_bad++;
    if (busy) busy_cyc++;
    if (wb_valid) begin
      if (wb_cnt == 0) first_wb_ctrl_lo = int'(wb_ctrl[11:0]);
      if (wb_cnt < 16) wb_seq[wb_cnt] = int'(wb_ch);
      wb_cnt++;
      last_src = wb_src; last_dst = wb_dst; last_ctrl = wb_ctrl;
    end
    if (done_valid) begin done_cnt++; last_done_ch = int'(done_ch); end
    if (err_valid)  begin err_cnt++;  last_err_ch  = int'(err_ch);  end
    mem_ready = 1'b0;
    if (mem_valid) begin
      if (waitc >= dly) begin
        mem_ready = 1'b1;
        waitc = 0;
        dly = (dly + 1) % 3;
        acc_cnt++;
        if (mem_we) begin
          wr_cnt++;
          for (int j = 0; j < (1 << mem_size); j++)
            mem[(int'(mem_addr[7:0]) + j) % 256] = mem_wdata[8*j +: 8];
        end else begin
          mem_rdata = '0;
          for (int j = 0; j < (1 << mem_size); j++)
            mem_rdata[8*j +: 8] = mem[(int'(mem_addr[7:0]) + j) % 256];
        end
      end else begin
        waitc++;
      end
    end
    prev_wait  = mem_valid && !mem_ready;
    prev_addr  = mem_addr;
    prev_we    = mem_we;
    prev_wdata = mem_wdata;
  end

  task automatic clr_cnt();
    @(posedge clk);
    acc_cnt = 0; wr_cnt = 0; wb_cnt = 0; done_cnt = 0; err_cnt = 0; busy_cyc = 0;
    last_done_ch = -1; last_err_ch = -1; first_wb_ctrl_lo = -1;
    for (int i = 0; i < 16; i++) wb_seq[i] = -1;
  endtask

  task automatic load(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [31:0] c, input logic [31:0] f);
    @(negedge clk);
    ld_valid = 1'b1; ld_ch = CHW'(ch); ld_src = s; ld_dst = d; ld_ctrl = c; ld_conf = f;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCH; c++) load(c, '0, '0, '0, '0);
  endtask

  task automatic kick();
    @(negedge clk); req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctrl(int swc, int dwc, int si, int di, int cnt);
    return 32'h8000_8000 | (32'(di) << 27) | (32'(si) << 26) | (32'(dwc) << 21) |
           (32'(swc) << 18) | 32'(cnt);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; glob_en = 1'b1; req_i = 1'b0; ld_valid = 1'b0; ld_ch = '0;
    ld_src = '0; ld_dst = '0; ld_ctrl = '0; ld_conf = '0;
    mem_ready = 1'b0; mem_rdata = '0; prev_wait = 1'b0; hold_bad = 0;
    prev_addr = '0; prev_we = 1'b0; prev_wdata = '0;
    last_src = '0; last_dst = '0; last_ctrl = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clr_cnt();
    @(negedge clk);
    // R1: quiet after reset
    chk(!busy && !mem_valid && !wb_valid && !done_valid && !err_valid, "R1 reset outputs",
        {busy, mem_valid, wb_valid, done_valid, err_valid}, 0);

    // R3 R4 R5 R6 R7: sweep widths, increments, counts on channel 0
    for (int swc = 0; swc < 3; swc++)
      for (int dwc = 0; dwc < 3; dwc++)
        for (int si = 0; si < 2; si++)
          for (int di = 0; di < 2; di++)
            for (int cnt = 1; cnt < 4; cnt++) begin
              int s_b, d_b, nw, mis;
              logic [7:0] rb [4];
              s_b = 1 << swc; d_b = 1 << dwc;
              nw = (s_b > d_b) ? s_b / d_b : 1;
              for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 13 + swc + cnt); expm[i] = mem[i]; end
              for (int u = 0; u < cnt; u++) begin
                int sa, da;
                sa = 16 + (si != 0 ? u * s_b : 0);
                da = 128 + (di != 0 ? u * s_b : 0);
                for (int j = 0; j < 4; j++) rb[j] = (j < s_b) ? expm[sa + j] : 8'h00;
                for (int k = 0; k < nw; k++)
                  for (int j = 0; j < d_b; j++)
                    expm[da + k * d_b + j] = (k * d_b + j < 4) ? rb[k * d_b + j] : 8'h00;
              end
              clr_cnt();
              load(0, 32'd16, 32'd128, mk_ctrl(swc, dwc, si, di, cnt), 32'h1);
              kick();
              wait_idle();
              mis = 0;
              for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) mis++;
              chk(mis == 0, "R4 memory image", mis, 0);
              chk(wr_cnt == cnt * nw, "R4 write count", wr_cnt, cnt * nw);
              chk(acc_cnt == cnt * (nw + 1), "R3 access count", acc_cnt, cnt * (nw + 1));
              chk(last_src == 32'(16 + (si != 0 ? cnt * s_b : 0)), "R3 final source",
                  last_src, 16 + (si != 0 ? cnt * s_b : 0));
              chk(last_dst == 32'(128 + (di != 0 ? cnt * s_b : 0)), "R5 final destination",
                  last_dst, 128 + (di != 0 ? cnt * s_b : 0));
              chk(wb_cnt == cnt && last_ctrl == (mk_ctrl(swc, dwc, si, di, cnt) & 32'hFFFF_F000),
                  "R6 write-back control", last_ctrl, mk_ctrl(swc, dwc, si, di, cnt) & 32'hFFFF_F000);
              chk(first_wb_ctrl_lo == cnt - 1, "R6 first decremented count", first_wb_ctrl_lo, cnt - 1);
              chk(done_cnt == 1 && last_done_ch == 0, "R7 completion", done_cnt, 1);
            end

    // R2: global enable low ignores requests, halted channel skipped
    clear_all();
    glob_en = 1'b0;
    load(0, 32'd0, 32'd64, mk_ctrl(0, 0, 1, 1, 1), 32'h1);
    load(1, 32'd4, 32'd96, mk_ctrl(0, 0, 1, 1, 1), 32'h1 | (32'h1 << 18));
    clr_cnt();
    kick();
    repeat (10) @(negedge clk);
    chk(busy_cyc == 0 && acc_cnt == 0, "R2 gated by global enable", busy_cyc + acc_cnt, 0);
    glob_en = 1'b1;
    clr_cnt();
    kick();
    wait_idle();
    chk(wb_cnt == 1 && wb_seq[0] == 0, "R2 halted channel skipped", wb_cnt, 1);

    // R7: count zero completes without memory access, then stays disabled
    clear_all();
    load(2, 32'd0, 32'd64, mk_ctrl(0, 0, 1, 1, 0), 32'h1);
    clr_cnt();
    kick();
    wait_idle();
    chk(done_cnt == 1 && last_done_ch == 2 && acc_cnt == 0, "R7 zero count", acc_cnt, 0);
    clr_cnt();
    kick();
    wait_idle();
    chk(done_cnt == 0, "R7 enable cleared", done_cnt, 0);

    // R8: non memory-to-memory flow and oversize width
    clear_all();
    load(1, 32'd0, 32'd64, mk_ctrl(0, 0, 1, 1, 2), 32'h1 | (32'd2 << 11));
    clr_cnt();
    kick();
    wait_idle();
    chk(err_cnt == 1 && last_err_ch == 1 && acc_cnt == 0 && wb_cnt == 0, "R8 flow type error",
        err_cnt, 1);
    clr_cnt();
    kick();
    wait_idle();
    chk(err_cnt == 0 && acc_cnt == 0, "R8 faulted channel disabled", err_cnt, 0);
    load(2, 32'd0, 32'd64, mk_ctrl(3, 0, 1, 1, 1), 32'h1);
    clr_cnt();
    kick();
    wait_idle();
    chk(err_cnt == 1 && last_err_ch == 2 && acc_cnt == 0, "R8 width code error", err_cnt, 1);

    // R9: two channels interleave one unit per visit
    clear_all();
    load(3, 32'd40, 32'd200, mk_ctrl(0, 0, 1, 1, 2), 32'h1);
    load(0, 32'd0, 32'd160, mk_ctrl(0, 0, 1, 1, 2), 32'h1);
    clr_cnt();
    kick();
    wait_idle();
    chk(wb_seq[0] == 0 && wb_seq[1] == 3 && wb_seq[2] == 0 && wb_seq[3] == 3 && wb_cnt == 4,
        "R9 interleave order", {wb_seq[0][3:0], wb_seq[1][3:0], wb_seq[2][3:0], wb_seq[3][3:0]},
        16'h0303);

    // R10: pass length and pending request
    clear_all();
    clr_cnt();
    kick();
    wait_idle();
    chk(busy_cyc == NCH, "R10 single empty pass", busy_cyc, NCH);
    clr_cnt();
    @(negedge clk); req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
    @(negedge clk); req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
    wait_idle();
    chk(busy_cyc == 2 * NCH, "R10 request during pass", busy_cyc, 2 * NCH);

    // R11: request fields held while waiting
    chk(hold_bad == 0, "R11 stable while stalled", hold_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule